// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This unit is the shift stage of a 64-bit integer core. Each clock it takes a 32-bit instruction word and the values of its two source registers. It recognises sixteen shift and rotate instructions and registers the outcome. The shift kinds are left logical, right logical, right arithmetic and rotate right. Each kind comes in a 32-bit word width and a 64-bit doubleword width. Each takes its amount either from the second register or from an immediate field.

Word forms work only on the low 32 bits of the first operand. They sign-extend their 32-bit result to 64 bits. Doubleword forms use the full operand. The register file, hazard handling and exceptions live elsewhere. The unit reports whether the word was one of its instructions, the destination register index and the result.

Top module: `shift_exec_unit`

## Requirements
- R1: Outputs are registered and appear one clock after the inputs are sampled. On a recognised instruction `rd_idx_o` carries instruction bits [4:0] and `valid_o` is 1.
- R2: Register-amount forms match bits [31:15] against prefix 000000000001 followed by a 5-bit code. The codes are 01110 word shift-left, 01111 word logical right, 10000 word arithmetic right, 10001 doubleword shift-left, 10010 doubleword logical right, 10011 doubleword arithmetic right, 10110 word rotate and 10111 doubleword rotate.
- R3: Word immediate forms match bits [31:15] against prefix 000000000100 followed by a 5-bit code. The codes are 00001 shift-left, 01001 logical right, 10001 arithmetic right and 11001 rotate. The amount is the unsigned field in bits [14:10].
- R4: Doubleword immediate forms match bits [31:16] against prefix 000000000100 followed by a 4-bit code. The codes are 0001 shift-left, 0101 logical right, 1001 arithmetic right and 1101 rotate. The amount is the unsigned field in bits [15:10].
- R5: A register-supplied amount uses only bits [4:0] of the second operand for word forms and only bits [5:0] for doubleword forms. Higher bits have no effect.
- R6: Word shifts read only bits [31:0] of the first operand. A logical right shift fills with zeros from bit 31 down. An arithmetic right shift fills with copies of bit 31.
- R7: Every word-form result has bits [63:32] equal to its bit 31.
- R8: A word rotate circulates bits [31:0] right by the amount. A doubleword rotate circulates all 64 bits.
- R9: An amount of zero returns the operand unchanged. For word forms this is the low 32 bits, sign-extended.
- R10: An instruction word matching none of the sixteen patterns gives `valid_o`=0, `result_o`=0 and `rd_idx_o`=0.
- R11: While `rst_ni` is low all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_i | input | 32 | Instruction word |
| rj_val_i | input | 64 | Value of the shifted source register |
| rk_val_i | input | 64 | Value of the amount source register |
| result_o | output | 64 | Registered result |
| rd_idx_o | output | 5 | Registered destination register index |
| valid_o | output | 1 | Registered flag: instruction recognised |

## Verification
A single output register stage sits between the inputs and every output. The result, the destination index and the valid flag are therefore all due on the first rising edge after the inputs are presented. The bench drives each instruction on a falling edge. It reads all three outputs on the next falling edge, half a period after the capturing edge. Expected values come from bit-serial shift loops in the bench. The bench runs random operands and amounts and adds amounts 0, 31, 32 and 63.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {SH_SLL, SH_SRL, SH_SRA, SH_ROR} shift_kind_e;

  localparam int unsigned SH_AMT_W = 6;
  localparam int unsigned RD_W     = 5;

  localparam logic [11:0] PFX_REG = 12'b0000_0000_0001;
  localparam logic [11:0] PFX_IMM = 12'b0000_0000_0100;

  typedef struct packed {
    logic                valid;
    logic                word;
    shift_kind_e         kind;
    logic [SH_AMT_W-1:0] amt;
    logic [RD_W-1:0]     rd;
  } shift_ctl_t;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_pkg::*;
(
  input  logic [31:0]         insn_i,
  input  logic [SH_AMT_W-1:0] rk_amt_i,
  output shift_ctl_t          ctl_o
);
  logic unused_rj_field;
  assign unused_rj_field = ^insn_i[9:5];

  always_comb begin
    logic [1:0] src; // 0 none, 1 register, 2 word imm, 3 dword imm
    ctl_o = '0;
    src   = 2'd0;
    casez (insn_i[31:15])
      {PFX_REG, 5'b01110}: begin src = 2'd1; ctl_o.word = 1'b1; ctl_o.kind = SH_SLL; end
      {PFX_REG, 5'b01111}: begin src = 2'd1; ctl_o.word = 1'b1; ctl_o.kind = SH_SRL; end
      {PFX_REG, 5'b10000}: begin src = 2'd1; ctl_o.word = 1'b1; ctl_o.kind = SH_SRA; end
      {PFX_REG, 5'b10110}: begin src = 2'd1; ctl_o.word = 1'b1; ctl_o.kind = SH_ROR; end
      {PFX_REG, 5'b10001}: begin src = 2'd1; ctl_o.kind = SH_SLL; end
      {PFX_REG, 5'b10010}: begin src = 2'd1; ctl_o.kind = SH_SRL; end
      {PFX_REG, 5'b10011}: begin src = 2'd1; ctl_o.kind = SH_SRA; end
      {PFX_REG, 5'b10111}: begin src = 2'd1; ctl_o.kind = SH_ROR; end
      {PFX_IMM, 5'b00001}: begin src = 2'd2; ctl_o.word = 1'b1; ctl_o.kind = SH_SLL; end
      {PFX_IMM, 5'b01001}: begin src = 2'd2; ctl_o.word = 1'b1; ctl_o.kind = SH_SRL; end
      {PFX_IMM, 5'b10001}: begin src = 2'd2; ctl_o.word = 1'b1; ctl_o.kind = SH_SRA; end
      {PFX_IMM, 5'b11001}: begin src = 2'd2; ctl_o.word = 1'b1; ctl_o.kind = SH_ROR; end
      {PFX_IMM, 4'b0001, 1'b?}: begin src = 2'd3; ctl_o.kind = SH_SLL; end
      {PFX_IMM, 4'b0101, 1'b?}: begin src = 2'd3; ctl_o.kind = SH_SRL; end
      {PFX_IMM, 4'b1001, 1'b?}: begin src = 2'd3; ctl_o.kind = SH_SRA; end
      {PFX_IMM, 4'b1101, 1'b?}: begin src = 2'd3; ctl_o.kind = SH_ROR; end
      default: src = 2'd0;
    endcase
    case (src)
      2'd1:    ctl_o.amt = ctl_o.word ? {1'b0, rk_amt_i[4:0]} : rk_amt_i;
      2'd2:    ctl_o.amt = {1'b0, insn_i[14:10]};
      2'd3:    ctl_o.amt = insn_i[15:10];
      default: ctl_o.amt = '0;
    endcase
    ctl_o.valid = (src != 2'd0);
    ctl_o.rd    = ctl_o.valid ? insn_i[4:0] : '0;
  end
endmodule

// File: rtl/shift_lane.sv
module shift_lane
  import shift_pkg::*;
#(
  parameter int unsigned W     = 64,
  localparam int unsigned AW   = $clog2(W)
) (
  input  shift_kind_e   kind_i,
  input  logic [AW-1:0] amt_i,
  input  logic [W-1:0]  x_i,
  output logic [W-1:0]  y_o
);
  always_comb begin
    unique case (kind_i)
      SH_SLL:  y_o = x_i << amt_i;
      SH_SRL:  y_o = x_i >> amt_i;
      SH_SRA:  y_o = $signed(x_i) >>> amt_i;
      default: y_o = (x_i >> amt_i) | (x_i << (W - int'(amt_i)));
    endcase
  end
endmodule

// File: rtl/shift_exec_unit.sv
module shift_exec_unit
  import shift_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  localparam int unsigned HW  = XLEN / 2,
  localparam int unsigned AW  = $clog2(XLEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] rj_val_i,
  input  logic [XLEN-1:0] rk_val_i,
  output logic [XLEN-1:0] result_o,
  output logic [RD_W-1:0] rd_idx_o,
  output logic            valid_o
);
  shift_ctl_t      ctl;
  logic [HW-1:0]   y_word;
  logic [XLEN-1:0] y_dword;
  logic [XLEN-1:0] res_d;
  logic            ctl_word;
  logic [AW-1:0]   ctl_amt;
  logic            unused_rk;

  assign unused_rk = ^rk_val_i[XLEN-1:AW];

  shift_decode i_dec (
    .insn_i   (insn_i),
    .rk_amt_i (rk_val_i[AW-1:0]),
    .ctl_o    (ctl)
  );

  assign ctl_word = ctl.word;
  assign ctl_amt  = ctl.amt;

  shift_lane #(.W(HW)) i_lane_word (
    .kind_i (ctl.kind),
    .amt_i  (ctl.amt[AW-2:0]),
    .x_i    (rj_val_i[HW-1:0]),
    .y_o    (y_word)
  );

  shift_lane #(.W(XLEN)) i_lane_dword (
    .kind_i (ctl.kind),
    .amt_i  (ctl.amt),
    .x_i    (rj_val_i),
    .y_o    (y_dword)
  );

  always_comb begin
    if (!ctl.valid)    res_d = '0;
    else if (ctl.word) res_d = {{HW{y_word[HW-1]}}, y_word};
    else               res_d = y_dword;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      rd_idx_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      result_o <= res_d;
      rd_idx_o <= ctl.rd;
      valid_o  <= ctl.valid;
    end
  end
endmodule

// File: rtl/shift_exec_chk.sv
module shift_exec_chk #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned HW  = XLEN / 2,
  localparam int unsigned AW  = $clog2(XLEN)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [4:0]      insn_rd,
  input logic [XLEN-1:0] rj_val_i,
  input logic [XLEN-1:0] result_o,
  input logic [4:0]      rd_idx_o,
  input logic            valid_o,
  input logic            ctl_word,
  input logic [AW-1:0]   ctl_amt
);
  AST_RD_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> rd_idx_o == $past(insn_rd)); // R1

  AST_WORD_SEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(ctl_word)) |-> result_o[XLEN-1:HW] == {HW{result_o[HW-1]}}); // R7

  AST_ZERO_AMT_DWORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(ctl_word) && $past(ctl_amt) == '0) |-> result_o == $past(rj_val_i)); // R9

  AST_ZERO_AMT_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(ctl_word) && $past(ctl_amt) == '0)
      |-> result_o[HW-1:0] == $past(rj_val_i[HW-1:0])); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (result_o == '0 && rd_idx_o == '0)); // R10
endmodule

bind shift_exec_unit shift_exec_chk #(.XLEN(XLEN)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .insn_rd  (insn_i[4:0]),
  .rj_val_i (rj_val_i),
  .result_o (result_o),
  .rd_idx_o (rd_idx_o),
  .valid_o  (valid_o),
  .ctl_word (ctl_word),
  .ctl_amt  (ctl_amt)
);

// File: tb/test_shift_exec_unit.sv
`timescale 1ns/1ps
module test_shift_exec_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] insn_i = '0;
  logic [63:0] rj_val_i = '0;
  logic [63:0] rk_val_i = '0;
  logic [63:0] result_o;
  logic [4:0]  rd_idx_o;
  logic        valid_o;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  shift_exec_unit i_shift_exec_unit (
    .clk_i, .rst_ni, .insn_i, .rj_val_i, .rk_val_i, .result_o, .rd_idx_o, .valid_o
  );

  // op: 0..7 register forms, 8..11 word immediate, 12..15 doubleword immediate
  // kind: 0 left, 1 logical right, 2 arithmetic right, 3 rotate
  function automatic int op_kind(int op);
    case (op)
      0, 3, 8, 12:  return 0;
      1, 4, 9, 13:  return 1;
      2, 5, 10, 14: return 2;
      default:      return 3;
    endcase
  endfunction

  function automatic bit op_word(int op);
    return (op inside {0, 1, 2, 6, 8, 9, 10, 11});
  endfunction

  function automatic logic [31:0] make_insn(int op, logic [4:0] rd, logic [4:0] rj,
                                            logic [4:0] rk, logic [5:0] imm);
    logic [4:0] s5;
    logic [3:0] s4;
    if (op < 8) begin
      case (op)
        0: s5 = 5'b01110; 1: s5 = 5'b01111; 2: s5 = 5'b10000; 3: s5 = 5'b10001;
        4: s5 = 5'b10010; 5: s5 = 5'b10011; 6: s5 = 5'b10110; default: s5 = 5'b10111;
      endcase
      return {12'b000000000001, s5, rk, rj, rd};
    end else if (op < 12) begin
      case (op)
        8: s5 = 5'b00001; 9: s5 = 5'b01001; 10: s5 = 5'b10001; default: s5 = 5'b11001;
      endcase
      return {12'b000000000100, s5, imm[4:0], rj, rd};
    end else begin
      case (op)
        12: s4 = 4'b0001; 13: s4 = 4'b0101; 14: s4 = 4'b1001; default: s4 = 4'b1101;
      endcase
      return {12'b000000000100, s4, imm, rj, rd};
    end
  endfunction

  // bit-serial reference
  function automatic logic [63:0] ref_calc(int kind, bit word, int n, logic [63:0] a);
    logic [31:0] w;
    logic [63:0] d;
    w = a[31:0];
    d = a;
    for (int i = 0; i < n; i++) begin
      case (kind)
        0: begin w = {w[30:0], 1'b0};  d = {d[62:0], 1'b0};  end
        1: begin w = {1'b0, w[31:1]};  d = {1'b0, d[63:1]};  end
        2: begin w = {w[31], w[31:1]}; d = {d[63], d[63:1]}; end
        default: begin w = {w[0], w[31:1]}; d = {d[0], d[63:1]}; end
      endcase
    end
    return word ? {{32{w[31]}}, w} : d;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(int op, logic [63:0] a, logic [63:0] b, logic [5:0] imm, string tag);
    logic [4:0]  rd;
    logic [31:0] ins;
    logic [63:0] exp;
    int          n;
    rd  = 5'($urandom);
    ins = make_insn(op, rd, 5'($urandom), 5'($urandom), imm);
    if (op < 8) n = op_word(op) ? int'(b[4:0]) : int'(b[5:0]);
    else        n = op_word(op) ? int'(imm[4:0]) : int'(imm);
    exp = ref_calc(op_kind(op), op_word(op), n, a);
    @(negedge clk_i);
    insn_i = ins; rj_val_i = a; rk_val_i = b;
    @(negedge clk_i);
    check(valid_o === 1'b1, "R1 valid", 64'(valid_o), 64'd1);
    check(rd_idx_o === rd, "R1 rd", 64'(rd_idx_o), 64'(rd));
    check(result_o === exp, tag, result_o, exp);
  endtask

  task automatic apply_bad(logic [31:0] ins);
    @(negedge clk_i);
    insn_i = ins; rj_val_i = {$urandom, $urandom}; rk_val_i = {$urandom, $urandom};
    @(negedge clk_i);
    check(valid_o === 1'b0, "R10 valid", 64'(valid_o), 64'd0);
    check(rd_idx_o === 5'd0, "R10 rd", 64'(rd_idx_o), 64'd0);
    check(result_o === 64'd0, "R10 result", result_o, 64'd0);
  endtask

  function automatic string grp_tag(int op);
    return (op < 8) ? "R2" : (op < 12) ? "R3" : "R4";
  endfunction

  initial begin
    void'($urandom(32'd7319));
    insn_i   = make_insn(3, 5'd9, 5'd1, 5'd2, 6'd0);
    rj_val_i = 64'h1234_5678_9abc_def0;
    repeat (3) @(negedge clk_i);
    check(valid_o === 1'b0 && rd_idx_o === 5'd0, "R11 ctrl", {59'd0, rd_idx_o}, 64'd0);
    check(result_o === 64'd0, "R11 result", result_o, 64'd0);
    rst_ni = 1'b1;

    // random sweep over all sixteen opcodes
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 24; k++)
        apply(op, {$urandom, $urandom}, {$urandom, $urandom}, 6'($urandom), grp_tag(op));
    end

    // boundary amounts
    for (int op = 0; op < 16; op++) begin
      apply(op, 64'h8000_0001_8000_0001, 64'd0,  6'd0,  "R9 zero amount");
      apply(op, 64'hF0F0_0000_7FFF_FFFE, 64'd31, 6'd31, grp_tag(op));
      apply(op, 64'hA5A5_5A5A_C3C3_3C3C, 64'd32, 6'd32, grp_tag(op));
      apply(op, 64'h8000_0000_0000_0001, 64'd63, 6'd63, grp_tag(op));
    end

    // R5: upper amount bits ignored
    apply(0, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFE3, 6'd0, "R5 word mask");
    apply(3, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFC7, 6'd0, "R5 dword mask");
    apply(6, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0021, 6'd0, "R5 word rot mask");
    // R6: low half only, fill behaviour
    apply(1,  64'hDEAD_BEEF_8000_0010, 64'd4, 6'd0, "R6 srl word");
    apply(2,  64'hDEAD_BEEF_8000_0010, 64'd4, 6'd0, "R6 sra word");
    apply(10, 64'h0000_0000_F000_0000, 64'd0, 6'd28, "R6 srai word");
    apply(9,  64'hFFFF_FFFF_7000_0000, 64'd0, 6'd1, "R6 srli word");
    // R7: bit 31 produced by a left shift
    apply(0, 64'h0000_0000_4000_0000, 64'd1, 6'd0, "R7 sll word");
    apply(8, 64'hFFFF_FFFF_0000_0001, 64'd0, 6'd31, "R7 slli word");
    // R8: rotates
    apply(6,  64'hFFFF_FFFF_0000_0001, 64'd1, 6'd0, "R8 rotr word");
    apply(11, 64'h0000_0000_8765_4321, 64'd0, 6'd8, "R8 rotri word");
    apply(15, 64'h0123_4567_89AB_CDEF, 64'd0, 6'd36, "R8 rotri dword");
    apply(7,  64'h0000_0000_0000_0001, 64'd1, 6'd0, "R8 rotr dword");

    // R10: unmatched encodings
    apply_bad(32'h0000_0000);
    apply_bad(32'hFFFF_FFFF);
    apply_bad({12'b000000000001, 5'b10100, 15'h1234});
    apply_bad({12'b000000000100, 5'b00000, 15'h0abc});
    apply_bad({12'b000000000100, 4'b0011, 16'h5555});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule